// File: doc/BRIEF.md
# Platform Interrupt Controller

This block gathers up to `NSRC` external interrupt request lines and distributes them to `NCTX` processor contexts. A gateway sits on each source line and records a pending request. The line can be set to fire on a rising edge or on a high level. Every source has a small priority value. Every context has its own enable mask and its own priority threshold. A context's interrupt output is raised whenever at least one enabled, pending source has a priority strictly above that context's threshold.

Software drives the block through a plain 32-bit register port. A read of a context's claim register returns the ID of the best eligible source and retires its pending request at the same time. While that source is being serviced it cannot raise a new request. When software writes the same ID back to the claim register, the service ends and the gateway accepts requests again. Source ID 0 is reserved: it never exists, and a claim value of 0 means nothing is waiting.

Top module: `ext_irq_hub`

## Requirements
- R1: Source 0 does not exist. Its priority word (offset 0x0), its enable bit (bit 0 of each context's first enable word) and its pending bit (bit 0 at 0x1000) always read 0. A claim that returns 0 means no interrupt is available.
- R2: The priority of source n is held at byte offset 4*n. It is 3 bits wide and resets to 0. Bits 31..3 of the word read as 0.
- R3: The enable bits of context c start at 0x2000 + 0x80*c. Source n is held in word n/32 at bit n%32. All enable bits reset to 0.
- R4: The pending bits can be read at 0x1000, with source n in word n/32 at bit n%32. The trigger-mode bits sit at 0x1080 in the same layout: 1 selects rising edge and 0 selects high level. The reset value is all level.
- R5: The threshold of context c is at 0x200000 + 0x1000*c, and its claim register is at that address + 4. `ctx_irq[c]` is raised only by a source that is enabled for c, pending, and has a priority strictly greater than the threshold. A threshold of 7 masks every source.
- R6: A read of context c's claim register returns the ID of its best eligible source and clears that source's pending bit. The read returns 0 when no source is eligible.
- R7: The highest priority wins the claim. Among sources of equal priority, the lowest ID wins.
- R8: A source with priority 0 never interrupts and is never claimed, although its pending bit is still recorded.
- R9: A claimed source stays not pending until a completion (a write of its ID to a claim register) arrives. A completion is ignored when the ID is not enabled for that context.
- R10: In edge mode, a rising edge makes the source pending. An edge that arrives while the source is pending or in service is held and re-raised when the completion arrives. A line held steadily high produces only one request.
- R11: In level mode, the pending bit follows the input while the source is not in service. After completion, the source is pending again if the input is still high.
- R12: Reads of unimplemented addresses return 0, and writes to them have no effect.
- R13: `ctx_irq[c]` is high exactly when a claim read of context c would return a nonzero ID.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Register read strobe; a claim read takes effect at the clock edge |
| wr_en | input | 1 | Register write strobe |
| addr | input | 32 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| src_irq | input | NSRC (31) | Request line of sources 1..NSRC |
| ctx_irq | output | NCTX (2) | Interrupt request to each context |

## Verification
The first pattern is a single level source swept against thresholds below, equal to and above its priority. It shows that the comparison is strict and that the maximum threshold masks everything. The second pattern raises three sources at once, two of them at the same priority. Successive claims then show the ordering by priority and the lowest-ID tie-break. The third pattern pulses an edge source while it is in service and then holds its line steady high. This separates the held edge, which fires once after completion, from a level that does not retrigger. A fourth pattern routes a source only to the second context, which shows that the contexts are independent and that a completion sent to the wrong context is ignored.

// File: rtl/irqhub_pkg.sv
package irqhub_pkg;

    // Register map anchors (byte addresses)
    localparam logic [31:0] PRIO_BASE  = 32'h0000_0000;
    localparam logic [31:0] PEND_BASE  = 32'h0000_1000;
    localparam logic [31:0] MODE_BASE  = 32'h0000_1080;
    localparam logic [31:0] EN_BASE    = 32'h0000_2000;
    localparam logic [31:0] EN_STRIDE  = 32'h0000_0080;
    localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
    localparam logic [31:0] CTX_STRIDE = 32'h0000_1000;
    localparam logic [31:0] CLAIM_OFS  = 32'h0000_0004;

    // Per-source gateway state
    typedef struct packed {
        logic prev;   // last sampled input
        logic pend;   // request waiting to be claimed
        logic busy;   // claimed, waiting for completion
        logic held;   // edge captured while pending or busy
    } gate_t;

    function automatic logic [31:0] en_addr(input int c, input int w);
        return EN_BASE + EN_STRIDE * 32'(c) + 32'(4 * w);
    endfunction

    function automatic logic [31:0] thr_addr(input int c);
        return CTX_BASE + CTX_STRIDE * 32'(c);
    endfunction

    function automatic logic [31:0] claim_addr(input int c);
        return CTX_BASE + CTX_STRIDE * 32'(c) + CLAIM_OFS;
    endfunction

endpackage

// File: rtl/irqhub_gate.sv
module irqhub_gate
    import irqhub_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    input  logic edge_mode,
    input  logic take,
    input  logic finish,
    output logic pending
);

    gate_t q, d;
    logic  rise;

    always_comb begin
        d      = q;
        d.prev = level_in;
        rise   = level_in & ~q.prev;

        if (take) begin
            d.pend = 1'b0;
            d.busy = 1'b1;
        end

        if (edge_mode) begin
            if (rise) begin
                if (q.pend || q.busy) d.held = 1'b1;
                else                  d.pend = 1'b1;
            end
            if (finish && q.busy) begin
                d.busy = 1'b0;
                if (q.held || rise) begin
                    d.pend = 1'b1;
                    d.held = 1'b0;
                end
            end
        end else begin
            d.held = 1'b0;
            if (!q.busy && !take) d.pend = level_in;
            if (finish && q.busy) d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pending = q.pend;

endmodule

// File: rtl/irqhub_pick.sv
module irqhub_pick #(
    parameter int NSRC   = 31,
    parameter int PRIO_W = 3,
    localparam int ID_W  = $clog2(NSRC + 1)
) (
    input  logic [NSRC:0]             pend,
    input  logic [NSRC:0]             en,
    input  logic [NSRC:0][PRIO_W-1:0] prio,
    input  logic [PRIO_W-1:0]         thr,
    output logic [ID_W-1:0]           best
);

    logic [PRIO_W-1:0] best_p;

    // Strictly-greater update keeps the lowest ID on a tie
    always_comb begin
        best   = '0;
        best_p = '0;
        for (int k = 0; k <= NSRC; k++) begin
            if (pend[k] && en[k] && (prio[k] > thr) && (prio[k] > best_p)) begin
                best_p = prio[k];
                best   = ID_W'(k);
            end
        end
    end

endmodule

// File: rtl/ext_irq_hub.sv
module ext_irq_hub
    import irqhub_pkg::*;
#(
    parameter int NSRC   = 31,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [31:0]       addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [NSRC:1]     src_irq,
    output logic [NCTX-1:0]   ctx_irq
);

    localparam int ID_W   = $clog2(NSRC + 1);
    localparam int NWORDS = (NSRC + 32) / 32;
    localparam int TOT    = NWORDS * 32;
    localparam logic [TOT-1:0] SRC_MASK = (TOT'(1) << (NSRC + 1)) - TOT'(2);

    typedef struct packed {
        logic [NSRC:0][PRIO_W-1:0]  prio;
        logic [TOT-1:0]             mode;
        logic [NCTX-1:0][TOT-1:0]   en;
        logic [NCTX-1:0][PRIO_W-1:0] thr;
    } regs_t;

    regs_t st_q, st_d;

    logic [NSRC:0]               pend_bits;
    logic [TOT-1:0]              pend_wide;
    logic [NSRC:1]               claim_pulse;
    logic [NSRC:1]               done_pulse;
    logic [NCTX-1:0][ID_W-1:0]   best_id;
    logic [NCTX-1:0][PRIO_W-1:0] thr_vec;

    assign pend_bits[0] = 1'b0;
    assign pend_wide    = TOT'(pend_bits);
    assign thr_vec      = st_q.thr;

    // One gateway per real source
    for (genvar k = 1; k <= NSRC; k++) begin : g_src
        irqhub_gate u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .level_in (src_irq[k]),
            .edge_mode(st_q.mode[k]),
            .take     (claim_pulse[k]),
            .finish   (done_pulse[k]),
            .pending  (pend_bits[k])
        );
    end

    // One arbiter per context
    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        irqhub_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_pick (
            .pend(pend_bits),
            .en  (st_q.en[c][NSRC:0]),
            .prio(st_q.prio),
            .thr (st_q.thr[c]),
            .best(best_id[c])
        );
        assign ctx_irq[c] = |best_id[c];
    end

    // Register decode, next state and claim/complete pulses
    always_comb begin
        st_d        = st_q;
        rdata       = '0;
        claim_pulse = '0;
        done_pulse  = '0;

        for (int k = 1; k <= NSRC; k++) begin
            if (addr == PRIO_BASE + 32'(4 * k)) begin
                rdata = 32'(st_q.prio[k]);
                if (wr_en) st_d.prio[k] = wdata[PRIO_W-1:0];
            end
        end

        for (int w = 0; w < NWORDS; w++) begin
            if (addr == PEND_BASE + 32'(4 * w)) begin
                rdata = pend_wide[w*32 +: 32];
            end
            if (addr == MODE_BASE + 32'(4 * w)) begin
                rdata = st_q.mode[w*32 +: 32];
                if (wr_en) st_d.mode[w*32 +: 32] = wdata & SRC_MASK[w*32 +: 32];
            end
            for (int c = 0; c < NCTX; c++) begin
                if (addr == en_addr(c, w)) begin
                    rdata = st_q.en[c][w*32 +: 32];
                    if (wr_en) st_d.en[c][w*32 +: 32] = wdata & SRC_MASK[w*32 +: 32];
                end
            end
        end

        for (int c = 0; c < NCTX; c++) begin
            if (addr == thr_addr(c)) begin
                rdata = 32'(st_q.thr[c]);
                if (wr_en) st_d.thr[c] = wdata[PRIO_W-1:0];
            end
            if (addr == claim_addr(c)) begin
                rdata = 32'(best_id[c]);
                for (int k = 1; k <= NSRC; k++) begin
                    if (rd_en && best_id[c] == ID_W'(k)) claim_pulse[k] = 1'b1;
                    if (wr_en && wdata == 32'(k) && st_q.en[c][k]) done_pulse[k] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/ext_irq_hub_chk.sv
module ext_irq_hub_chk
    import irqhub_pkg::*;
#(
    parameter int NSRC   = 31,
    parameter int NCTX   = 2,
    parameter int PRIO_W = 3,
    localparam int ID_W  = $clog2(NSRC + 1)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rd_en,
    input logic [31:0]                addr,
    input logic [31:0]                rdata,
    input logic [NCTX-1:0]            ctx_irq,
    input logic [NCTX-1:0][PRIO_W-1:0] thr_vec,
    input logic [NSRC:0]              pend_vec
);

    logic claim_any;

    always_comb begin
        claim_any = 1'b0;
        for (int c = 0; c < NCTX; c++) begin
            if (addr == claim_addr(c)) claim_any = 1'b1;
        end
    end

    // R1: the non-existent source 0 reads as zero
    a_r1_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == PRIO_BASE) |-> (rdata == 32'h0));

    a_r1_pend_bit0: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == PEND_BASE) |-> (rdata[0] == 1'b0));

    // R2: upper bits of a priority word are zero
    a_r2_prio_width: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr < PEND_BASE) |-> (rdata[31:PRIO_W] == '0));

    // R6: a nonzero claim clears that source's pending bit
    a_r6_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && claim_any && rdata != 32'h0 && rdata <= 32'(NSRC))
        |=> !pend_vec[$past(rdata[ID_W-1:0])]);

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        // R5: the maximum threshold masks the context
        a_r5_thr_mask: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_vec[c] == {PRIO_W{1'b1}}) |-> !ctx_irq[c]);

        // R13: output agrees with what a claim would return
        a_r13_irq_matches_claim: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && addr == claim_addr(c)) |-> ((rdata != 32'h0) == ctx_irq[c]));
    end

endmodule

bind ext_irq_hub ext_irq_hub_chk #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .addr    (addr),
    .rdata   (rdata),
    .ctx_irq (ctx_irq),
    .thr_vec (thr_vec),
    .pend_vec(pend_bits)
);

// File: tb/ext_irq_hub_bench.sv
`timescale 1ns/100ps
module ext_irq_hub_bench;

    localparam int NSRC = 31;
    localparam int NCTX = 2;

    localparam logic [31:0] PEND = 32'h1000;
    localparam logic [31:0] MODE = 32'h1080;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              rd_en, wr_en;
    logic [31:0]       addr, wdata, rdata;
    logic [NSRC:1]     src_irq;
    logic [NCTX-1:0]   ctx_irq;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    ext_irq_hub #(.NSRC(NSRC), .NCTX(NCTX), .PRIO_W(3)) u_ext_irq_hub (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .src_irq(src_irq), .ctx_irq(ctx_irq)
    );

    function automatic logic [31:0] prio_a(input int n); return 32'(4 * n); endfunction
    function automatic logic [31:0] en_a(input int c);   return 32'h2000 + 32'(c * 'h80); endfunction
    function automatic logic [31:0] thr_a(input int c);  return 32'h20_0000 + 32'(c * 'h1000); endfunction
    function automatic logic [31:0] clm_a(input int c);  return 32'h20_0004 + 32'(c * 'h1000); endfunction

    // Monitor: compares every read with the scoreboard queue
    always @(negedge clk) begin
        if (rd_en) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard empty: rdata=%h", rdata);
            end else begin
                logic [31:0] e;
                string       t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s: addr=%h rdata=%h expected %h", t, addr, rdata, e);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    // Driver: pushes the expected value, then issues the read
    task automatic rd(input logic [31:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        addr = a; rd_en = 1'b1;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic [NCTX-1:0] e, input string t);
        @(negedge clk);
        checks++;
        if (ctx_irq !== e) begin
            errors++;
            $display("FAIL %s: ctx_irq=%b expected %b", t, ctx_irq, e);
        end
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
        addr = '0; wdata = '0; src_irq = '0;
        tick(3);
        rst_n = 1'b1;

        // Reset state
        rd(prio_a(5), 32'h0, "R2 reset priority");
        rd(en_a(0),   32'h0, "R3 reset enable");
        rd(MODE,      32'h0, "R4 reset mode");
        chk_irq(2'b00, "R13 reset output");
        rd(clm_a(0),  32'h0, "R6 R1 empty claim");

        // Field widths and source 0
        wr(prio_a(5), 32'hFFFF_FFFF);
        rd(prio_a(5), 32'h7, "R2 priority width");
        wr(prio_a(0), 32'h5);
        rd(prio_a(0), 32'h0, "R1 source 0 priority");
        wr(en_a(0), 32'hFFFF_FFFF);
        rd(en_a(0), 32'hFFFF_FFFE, "R1 R3 enable bit 0");
        wr(en_a(0), 32'h0);

        // Unimplemented addresses
        wr(32'h3000, 32'hFFFF_FFFF);
        rd(32'h3000, 32'h0, "R12 hole read");
        rd(32'h1004, 32'h0, "R12 missing pending word");
        rd(32'h20_0008, 32'h0, "R12 context hole");

        // Level source 3 against thresholds
        wr(prio_a(3), 32'h2);
        wr(en_a(0), 32'h8);
        src_irq[3] = 1'b1;
        tick(1);
        chk_irq(2'b01, "R5 R13 level raises ctx0");
        rd(PEND, 32'h8, "R4 R11 pending bit");
        rd(clm_a(1), 32'h0, "R3 ctx1 not enabled");
        wr(thr_a(0), 32'h2);
        chk_irq(2'b00, "R5 equal threshold masks");
        wr(thr_a(0), 32'h1);
        chk_irq(2'b01, "R5 lower threshold passes");
        wr(prio_a(3), 32'h7);
        wr(thr_a(0), 32'h7);
        chk_irq(2'b00, "R5 threshold 7 masks all");
        wr(prio_a(3), 32'h2);
        wr(thr_a(0), 32'h0);

        // Claim and completion
        rd(clm_a(0), 32'd3, "R6 claim returns id");
        rd(PEND, 32'h0, "R6 claim clears pending");
        chk_irq(2'b00, "R9 no request while in service");
        tick(2);
        wr(clm_a(1), 32'd3);
        tick(1);
        rd(PEND, 32'h0, "R9 wrong-context completion ignored");
        wr(clm_a(0), 32'd3);
        tick(1);
        rd(PEND, 32'h8, "R11 level re-pends after completion");
        src_irq[3] = 1'b0;
        tick(1);
        rd(PEND, 32'h0, "R11 pending follows low level");

        // Priority 0
        wr(prio_a(3), 32'h0);
        src_irq[3] = 1'b1;
        tick(1);
        chk_irq(2'b00, "R8 priority 0 silent");
        rd(clm_a(0), 32'h0, "R8 priority 0 not claimed");
        rd(PEND, 32'h8, "R8 pending still recorded");
        src_irq[3] = 1'b0;
        tick(1);

        // Ordering and tie-break
        wr(en_a(0), 32'h250);
        wr(prio_a(4), 32'h3);
        wr(prio_a(6), 32'h5);
        wr(prio_a(9), 32'h5);
        src_irq[4] = 1'b1; src_irq[6] = 1'b1; src_irq[9] = 1'b1;
        tick(1);
        rd(clm_a(0), 32'd6, "R7 tie lowest id first");
        rd(clm_a(0), 32'd9, "R7 tie second");
        rd(clm_a(0), 32'd4, "R7 lower priority last");
        rd(clm_a(0), 32'd0, "R6 none left");
        src_irq[4] = 1'b0; src_irq[6] = 1'b0; src_irq[9] = 1'b0;
        wr(clm_a(0), 32'd6);
        wr(clm_a(0), 32'd9);
        wr(clm_a(0), 32'd4);
        tick(1);
        rd(PEND, 32'h0, "R11 nothing pending after drop");

        // Edge source 10
        wr(MODE, 32'h400);
        rd(MODE, 32'h400, "R4 mode readback");
        wr(prio_a(10), 32'h4);
        wr(en_a(0), 32'h400);
        src_irq[10] = 1'b1; tick(1); src_irq[10] = 1'b0;
        rd(PEND, 32'h400, "R10 edge sets pending");
        rd(clm_a(0), 32'd10, "R10 edge claim");
        src_irq[10] = 1'b1; tick(1); src_irq[10] = 1'b0;
        tick(1);
        rd(PEND, 32'h0, "R9 R10 edge held during service");
        wr(clm_a(0), 32'd10);
        rd(PEND, 32'h400, "R10 held edge forwarded");
        rd(clm_a(0), 32'd10, "R10 second claim");
        wr(clm_a(0), 32'd10);
        tick(1);
        rd(PEND, 32'h0, "R10 no extra request");
        src_irq[10] = 1'b1;
        tick(1);
        rd(clm_a(0), 32'd10, "R10 steady high claim");
        wr(clm_a(0), 32'd10);
        tick(2);
        rd(PEND, 32'h0, "R10 steady high fires once");
        src_irq[10] = 1'b0;

        // Second context
        wr(prio_a(12), 32'h1);
        wr(en_a(1), 32'h1000);
        src_irq[12] = 1'b1;
        tick(1);
        chk_irq(2'b10, "R13 ctx1 only");
        rd(clm_a(0), 32'h0, "R3 ctx0 unaffected");
        rd(clm_a(1), 32'd12, "R6 ctx1 claim");
        chk_irq(2'b00, "R9 ctx1 in service");
        src_irq[12] = 1'b0;
        wr(clm_a(1), 32'd12);
        tick(2);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule